// File: doc/BRIEF.md
# Paged Frame Memory Raster Scan-Out Engine

This block turns a page-organised monochrome frame memory into a serial pixel raster. The memory stores eight vertically stacked pixels per byte, and a page row spans 132 bytes. The block shows a window of 96 source columns by 16 source lines. Each source pixel is enlarged by a factor of 4 in both directions. The output is therefore 384 pixels per line and 64 lines per frame, delivered one pixel per clock with no gaps.

A frame is produced only on request. The owner of the frame memory holds a redraw flag high when the picture has changed. The engine starts a frame when it sees that flag while it is idle. After the last pixel it raises a one-cycle clear strobe, so the owner can drop the flag. When the frame starts, the engine captures a vertical scroll value (the start line) and two override bits: invert and force-all-lit. These captured values hold for the whole frame.

Memory is read through a single synchronous read port with one cycle of latency. The engine issues each address one cycle before the pixel that needs it. Colour-depth conversion and the physical display are left to the consumer of the pixel stream.

Top module: `page_scanout`

## Requirements
- R1: While reset is asserted and right after it, `pix_valid_o`, `line_start_o`, `frame_done_o`, `redraw_clr_o` and `mem_rd_o` are all 0.
- R2: No frame begins while `redraw_i` is low. After a frame completes, the engine stays idle until `redraw_i` is raised again.
- R3: A frame delivers exactly 384 × 64 = 24576 pixels with `pix_valid_o` high on consecutive clocks, with no gap between the first and the last.
- R4: Output line `oy` draws from source line `(oy/4 + start_line) mod 64`, so the source line wraps past 63 back to 0.
- R5: For source line L and source column x (0..95), the engine reads byte address `132*(L/8) + 36 + x`. `mem_rd_o` is high with that address one cycle before the pixel is presented on `pix_o`. Output pixel k is read at `mem_addr_o` on the k-th cycle that has `mem_rd_o` high.
- R6: The source pixel is bit `L mod 8` of the fetched byte, where bit 0 is the least significant bit.
- R7: Output pixel `(ox, oy)` shows source column `ox/4` of output line `oy`'s source line. Each source pixel repeats on 4 adjacent clocks, and each source line repeats on 4 adjacent output lines.
- R8: When the captured force-all-lit bit is 1, every pixel of the frame is 1, whatever the memory contents and the invert bit.
- R9: When force-all-lit is 0 and the captured invert bit is 1, every pixel is the complement of the memory bit.
- R10: `line_start_o` is 1 on exactly the first pixel of each of the 64 output lines and 0 on every other pixel.
- R11: `frame_done_o` and `redraw_clr_o` are high together for exactly one cycle. That cycle comes immediately after the last valid pixel.
- R12: `start_line_i`, `inverse_i` and `all_on_i` are captured when a frame starts. Changing them during a frame has no effect on that frame's pixels or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redraw_i | input | 1 | Redraw request flag, held by the memory owner |
| start_line_i | input | 6 | Vertical scroll: source line shown on the first output line |
| inverse_i | input | 1 | Invert all pixels |
| all_on_i | input | 1 | Force every pixel lit; overrides invert |
| mem_rd_o | output | 1 | Frame memory read enable |
| mem_addr_o | output | 11 | Frame memory byte address |
| mem_data_i | input | 8 | Read data, valid one cycle after the address |
| pix_o | output | 1 | Pixel value |
| pix_valid_o | output | 1 | Pixel valid |
| line_start_o | output | 1 | First pixel of an output line |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| redraw_clr_o | output | 1 | One-cycle strobe telling the owner to drop the redraw flag |

## Verification
The bench uses start lines of 0, 61 and a random value. The value 61 crosses the wrap at line 63; a design that forgets the modulo would read beyond the last page and show garbage in the bottom rows. A random start line moves the bit select inside a byte and across page boundaries, which catches a swapped bit order or a missing column offset of 36. The bench changes the scroll and override inputs in the middle of a frame. A design that reads them live would produce a torn picture. The bench also checks pixel contiguity and the exact cycle of the end pulse. An off-by-one in the replication counters would drop or duplicate pixels. An engine that does not hold off while draining would start a second, unrequested frame.

// File: rtl/page_scanout_pkg.sv
package page_scanout_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SCAN  = 2'd1,
        SEQ_DRAIN = 2'd2,
        SEQ_DONE  = 2'd3
    } scan_state_e;

    typedef struct packed {
        logic invert;
        logic force_on;
    } pix_ovr_t;

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import page_scanout_pkg::*;
#(
    parameter int COLS   = 96,
    parameter int ROWS   = 16,
    parameter int MAG    = 4,
    parameter int LINE_W = 6,
    localparam int SX_W  = $clog2(COLS),
    localparam int SY_W  = $clog2(ROWS),
    localparam int MAG_W = $clog2(MAG > 1 ? MAG : 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redraw_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic              inverse_i,
    input  logic              all_on_i,
    output logic              issue_o,
    output logic [SX_W-1:0]   sx_o,
    output logic [SY_W-1:0]   sy_o,
    output logic              first_o,
    output logic              frame_done_o,
    output logic [LINE_W-1:0] start_line_o,
    output pix_ovr_t          ovr_o
);

    typedef struct packed {
        scan_state_e       st;
        logic [MAG_W-1:0]  hx;
        logic [SX_W-1:0]   sx;
        logic [MAG_W-1:0]  vy;
        logic [SY_W-1:0]   sy;
        logic [LINE_W-1:0] line0;
        pix_ovr_t          ovr;
    } seq_t;

    seq_t s_d, s_q;

    logic hx_end, sx_end, vy_end, sy_end, last_pix;

    always_comb begin
        hx_end   = (s_q.hx == MAG_W'(MAG - 1));
        sx_end   = (s_q.sx == SX_W'(COLS - 1));
        vy_end   = (s_q.vy == MAG_W'(MAG - 1));
        sy_end   = (s_q.sy == SY_W'(ROWS - 1));
        last_pix = hx_end && sx_end && vy_end && sy_end;

        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (redraw_i) begin
                    s_d.st             = SEQ_SCAN;
                    s_d.hx             = '0;
                    s_d.sx             = '0;
                    s_d.vy             = '0;
                    s_d.sy             = '0;
                    s_d.line0          = start_line_i;
                    s_d.ovr.invert     = inverse_i;
                    s_d.ovr.force_on   = all_on_i;
                end
            end
            SEQ_SCAN: begin
                if (last_pix) begin
                    s_d.st = SEQ_DRAIN;
                end else if (!hx_end) begin
                    s_d.hx = s_q.hx + 1'b1;
                end else begin
                    s_d.hx = '0;
                    if (!sx_end) begin
                        s_d.sx = s_q.sx + 1'b1;
                    end else begin
                        s_d.sx = '0;
                        if (!vy_end) begin
                            s_d.vy = s_q.vy + 1'b1;
                        end else begin
                            s_d.vy = '0;
                            s_d.sy = s_q.sy + 1'b1;
                        end
                    end
                end
            end
            SEQ_DRAIN: s_d.st = SEQ_DONE;
            default:   s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign issue_o      = (s_q.st == SEQ_SCAN);
    assign sx_o         = s_q.sx;
    assign sy_o         = s_q.sy;
    assign first_o      = (s_q.hx == '0) && (s_q.sx == '0);
    assign frame_done_o = (s_q.st == SEQ_DONE);
    assign start_line_o = s_q.line0;
    assign ovr_o        = s_q.ovr;

    AST_NO_START_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_IDLE && !redraw_i) |=> (s_q.st != SEQ_SCAN)); // R2

    AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_SCAN) |=> ($stable(s_q.line0) && $stable(s_q.ovr))); // R12

endmodule

// File: rtl/page_addr_gen.sv
module page_addr_gen #(
    parameter int COLS        = 96,
    parameter int ROWS        = 16,
    parameter int PAGE_STRIDE = 132,
    parameter int COL_OFFSET  = 36,
    parameter int PAGE_ROWS   = 8,
    parameter int LINE_W      = 6,
    parameter int ADDR_W      = 11,
    localparam int SX_W       = $clog2(COLS),
    localparam int SY_W       = $clog2(ROWS),
    localparam int BIT_W      = $clog2(PAGE_ROWS)
) (
    input  logic [SX_W-1:0]   sx_i,
    input  logic [SY_W-1:0]   sy_i,
    input  logic [LINE_W-1:0] start_line_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BIT_W-1:0]  bitsel_o
);

    logic [LINE_W-1:0]       line;
    logic [LINE_W-BIT_W-1:0] page;

    always_comb begin
        line     = LINE_W'(sy_i) + start_line_i;
        page     = line[LINE_W-1:BIT_W];
        bitsel_o = line[BIT_W-1:0];
        addr_o   = ADDR_W'(PAGE_STRIDE * int'(page) + COL_OFFSET + int'(sx_i));
    end

endmodule

// File: rtl/pixel_shaper.sv
module pixel_shaper
    import page_scanout_pkg::*;
#(
    parameter int BIT_W    = 3,
    localparam int BYTE_W  = 2 ** BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              first_i,
    input  logic [BIT_W-1:0]  bitsel_i,
    input  pix_ovr_t          ovr_i,
    input  logic [BYTE_W-1:0] mem_data_i,
    output logic              pix_o,
    output logic              valid_o,
    output logic              line_start_o
);

    typedef struct packed {
        logic             valid;
        logic             first;
        logic [BIT_W-1:0] bitsel;
    } stage_t;

    stage_t p_d, p_q;

    always_comb begin
        p_d.valid  = issue_i;
        p_d.first  = issue_i && first_i;
        p_d.bitsel = bitsel_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        valid_o      = p_q.valid;
        line_start_o = p_q.first;
        if (!p_q.valid)
            pix_o = 1'b0;
        else if (ovr_i.force_on)
            pix_o = 1'b1;
        else
            pix_o = mem_data_i[p_q.bitsel] ^ ovr_i.invert;
    end

    AST_VALID_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> valid_o); // R3

    AST_LINE_START_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> valid_o); // R10

endmodule

// File: rtl/page_scanout.sv
module page_scanout
    import page_scanout_pkg::*;
#(
    parameter int COLS        = 96,
    parameter int ROWS        = 16,
    parameter int MAG         = 4,
    parameter int PAGE_STRIDE = 132,
    parameter int COL_OFFSET  = 36,
    parameter int PAGE_ROWS   = 8,
    parameter int LINE_COUNT  = 64,
    localparam int LINE_W     = $clog2(LINE_COUNT),
    localparam int BIT_W      = $clog2(PAGE_ROWS),
    localparam int MEM_DEPTH  = PAGE_STRIDE * (LINE_COUNT / PAGE_ROWS),
    localparam int ADDR_W     = $clog2(MEM_DEPTH),
    localparam int SX_W       = $clog2(COLS),
    localparam int SY_W       = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redraw_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic              inverse_i,
    input  logic              all_on_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [PAGE_ROWS-1:0] mem_data_i,
    output logic              pix_o,
    output logic              pix_valid_o,
    output logic              line_start_o,
    output logic              frame_done_o,
    output logic              redraw_clr_o
);

    logic              issue;
    logic [SX_W-1:0]   sx;
    logic [SY_W-1:0]   sy;
    logic              first;
    logic              done;
    logic [LINE_W-1:0] line0;
    pix_ovr_t          ovr;
    logic [BIT_W-1:0]  bitsel;

    scan_sequencer #(
        .COLS   (COLS),
        .ROWS   (ROWS),
        .MAG    (MAG),
        .LINE_W (LINE_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .redraw_i     (redraw_i),
        .start_line_i (start_line_i),
        .inverse_i    (inverse_i),
        .all_on_i     (all_on_i),
        .issue_o      (issue),
        .sx_o         (sx),
        .sy_o         (sy),
        .first_o      (first),
        .frame_done_o (done),
        .start_line_o (line0),
        .ovr_o        (ovr)
    );

    page_addr_gen #(
        .COLS        (COLS),
        .ROWS        (ROWS),
        .PAGE_STRIDE (PAGE_STRIDE),
        .COL_OFFSET  (COL_OFFSET),
        .PAGE_ROWS   (PAGE_ROWS),
        .LINE_W      (LINE_W),
        .ADDR_W      (ADDR_W)
    ) u_addr (
        .sx_i         (sx),
        .sy_i         (sy),
        .start_line_i (line0),
        .addr_o       (mem_addr_o),
        .bitsel_o     (bitsel)
    );

    pixel_shaper #(
        .BIT_W (BIT_W)
    ) u_shape (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .first_i      (first),
        .bitsel_i     (bitsel),
        .ovr_i        (ovr),
        .mem_data_i   (mem_data_i),
        .pix_o        (pix_o),
        .valid_o      (pix_valid_o),
        .line_start_o (line_start_o)
    );

    assign mem_rd_o     = issue;
    assign frame_done_o = done;
    assign redraw_clr_o = done;

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (int'(mem_addr_o) < MEM_DEPTH)); // R5

    AST_DONE_AFTER_LAST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done_o) |-> $past(pix_valid_o)); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o); // R11

    AST_NO_PIXEL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !pix_valid_o); // R11

endmodule

// File: tb/page_scanout_tb_top.sv
module page_scanout_tb_top;

    localparam int OUT_W   = 384;
    localparam int OUT_H   = 64;
    localparam int TOTAL   = OUT_W * OUT_H;
    localparam int MEMSZ   = 1056;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_req = 1'b0;
    logic       redraw = 1'b0;
    logic [5:0] start_line = '0;
    logic       inverse = 1'b0;
    logic       all_on = 1'b0;
    logic       mem_rd;
    logic [10:0] mem_addr;
    logic [7:0] mem_data = '0;
    logic       pix, pix_valid, line_start, frame_done, redraw_clr;

    logic [7:0] mem [0:MEMSZ-1];

    int checks = 0;
    int failures = 0;
    int wd = 0;

    always #2 clk = ~clk;

    page_scanout dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .redraw_i     (redraw),
        .start_line_i (start_line),
        .inverse_i    (inverse),
        .all_on_i     (all_on),
        .mem_rd_o     (mem_rd),
        .mem_addr_o   (mem_addr),
        .mem_data_i   (mem_data),
        .pix_o        (pix),
        .pix_valid_o  (pix_valid),
        .line_start_o (line_start),
        .frame_done_o (frame_done),
        .redraw_clr_o (redraw_clr)
    );

    always @(posedge clk) begin
        if (!rst_n)          redraw <= 1'b0;
        else if (set_req)    redraw <= 1'b1;
        else if (redraw_clr) redraw <= 1'b0;
        if (mem_rd) mem_data <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int src_line(input int k, input int sl);
        return ((k / OUT_W) / 4 + sl) % 64;
    endfunction

    function automatic int exp_addr(input int k, input int sl);
        return 132 * (src_line(k, sl) / 8) + 36 + (k % OUT_W) / 4;
    endfunction

    function automatic logic exp_pix(input int k, input int sl, input bit inv, input bit on);
        logic [7:0] b;
        b = mem[exp_addr(k, sl)];
        if (on) return 1'b1;
        return b[src_line(k, sl) % 8] ^ inv;
    endfunction

    task automatic run_frame(input int sl, input bit inv, input bit on,
                             input bit disturb, input string tag);
        int idx = 0, rd = 0, cyc = 0, gaps = 0, bad_pix = 0, bad_addr = 0, bad_ls = 0;
        int first_bad = -1, quiet_bad = 0;
        bit started = 0;
        start_line = 6'(sl);
        inverse    = inv;
        all_on     = on;
        @(negedge clk) set_req = 1'b1;
        @(negedge clk) set_req = 1'b0;
        while (idx < TOTAL && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (mem_rd) begin
                if (rd < TOTAL && int'(mem_addr) != exp_addr(rd, sl)) bad_addr++;
                rd++;
            end
            if (pix_valid) begin
                if (pix !== exp_pix(idx, sl, inv, on)) begin
                    bad_pix++;
                    if (first_bad < 0) first_bad = idx;
                end
                if (line_start !== ((idx % OUT_W) == 0)) bad_ls++;
                idx++;
                started = 1;
                if (disturb && idx == 5000) begin
                    start_line = ~start_line;
                    inverse    = ~inverse;
                    all_on     = ~all_on;
                end
            end else if (started) begin
                gaps++;
            end
        end
        check(idx == TOTAL, "R3 pixel count", idx, TOTAL);
        check(gaps == 0, "R3 contiguous valid", gaps, 0);
        check(rd == TOTAL && bad_addr == 0, "R5 read addresses", bad_addr, 0);
        if (bad_pix != 0)
            $display("  first bad pixel index %0d (%s)", first_bad, tag);
        check(bad_pix == 0, tag, bad_pix, 0);
        check(bad_ls == 0, "R10 line start marks", bad_ls, 0);
        @(negedge clk);
        check(frame_done && redraw_clr && !pix_valid, "R11 done after last pixel",
              {frame_done, redraw_clr, pix_valid}, 3'b110);
        @(negedge clk);
        check(!frame_done && !redraw_clr, "R11 single-cycle pulse",
              {frame_done, redraw_clr}, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pix_valid || mem_rd || redraw) quiet_bad++;
        end
        check(quiet_bad == 0, "R2 no restart after clear", quiet_bad, 0);
        start_line = 6'(sl);
        inverse    = inv;
        all_on     = on;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            wd++;
            if (wd > 190000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", wd, 190000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int idle_bad = 0;
        void'($urandom(32'h0005_EED5));
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);

        repeat (3) @(negedge clk);
        check(!pix_valid && !frame_done && !redraw_clr && !mem_rd && !line_start,
              "R1 outputs during reset",
              {pix_valid, frame_done, redraw_clr, mem_rd, line_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pix_valid && !frame_done && !redraw_clr && !mem_rd,
              "R1 outputs after reset", {pix_valid, frame_done, redraw_clr, mem_rd}, 0);

        start_line = 6'd9;
        inverse    = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pix_valid || mem_rd || frame_done) idle_bad++;
        end
        check(idle_bad == 0, "R2 idle without redraw", idle_bad, 0);

        // plain frame: R4 R6 R7 with zero scroll
        run_frame(0, 1'b0, 1'b0, 1'b0, "R4 R6 R7 plain pixels");
        // wrap of the source line past 63, inverted, inputs disturbed mid-frame
        run_frame(61, 1'b1, 1'b0, 1'b1, "R4 R9 R12 wrap invert held");
        // force-all-lit overrides invert
        run_frame(22, 1'b1, 1'b1, 1'b0, "R8 all lit");
        // random scroll and invert
        run_frame(int'($urandom % 64), 1'($urandom), 1'b0, 1'b1, "R6 R7 R12 random scroll");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule